// File: doc/BRIEF.md
# Dual-Clock RAM With Selectable Read Mode

This block is a two-port memory with one write port and one read port, each running on its own clock. The two clocks have no fixed phase or frequency relation. Words are 18 bits wide and are addressed with 10 bits. With the default depth of 1024 words, every address reaches a real location.

A static mode input picks how the read port behaves. In clocked mode, the read address is captured on a read-clock edge at which the read enable is high. The stored word then appears on the output after that edge and stays there until the next enabled read edge. In flow-through mode, the output is a purely combinational function of the read address, and the read clock plays no part. A write to the address being watched shows up on the output right after the write-clock edge.

The memory contents are undefined after power-up until they are written. An active-low reset clears only the registered read word, so in clocked mode the output is zero after reset.

Top module: `flexread_ram`

## Requirements
- R1: On a rising edge of `wr_clk` with `wr_en` high, `wr_data` is stored at location `wr_addr`.
- R2: A `wr_clk` edge with `wr_en` low leaves every location unchanged.
- R3: With `rd_async` = 1 (flow-through mode), `rd_data` equals the word stored at `rd_addr`, with no read-clock edge involved.
- R4: In flow-through mode, when a write targets the address on `rd_addr`, `rd_data` keeps the old word until the write-clock edge and shows the new word after it.
- R5: With `rd_async` = 0 (clocked mode), a rising edge of `rd_clk` with `rd_en` high loads the word stored at `rd_addr` at that edge onto `rd_data`.
- R6: In clocked mode, a `rd_clk` edge with `rd_en` low leaves `rd_data` unchanged, even when `rd_addr` changes.
- R7: While `rst_n` is low, the registered read word is cleared. In clocked mode `rd_data` is all zeros after reset until the first enabled read.
- R8: In clocked mode, a word written at a `wr_clk` edge is returned by the first enabled `rd_clk` edge that follows it at the same address.
- R9: All locations from address 0 to address 1023 (the default depth) hold independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| wr_en | input | 1 | Write enable, sampled on `wr_clk` |
| wr_addr | input | 10 | Write address |
| wr_data | input | 18 | Write data |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Active-low reset of the registered read word |
| rd_async | input | 1 | Static read-mode select: 1 = flow-through, 0 = clocked |
| rd_en | input | 1 | Read enable, sampled on `rd_clk` in clocked mode |
| rd_addr | input | 10 | Read address |
| rd_data | output | 18 | Read data |

## Verification
The bench first writes a table of words that includes the two end addresses. It then reads each one back in both modes. A design that mixed up address bits would return a neighbour's word, and a flow-through path that was accidentally registered would return stale data.

Several directed tests follow:
- A write with the enable low goes to an address that already holds data. A design that ignored the enable would show the new word.
- In clocked mode, the address is moved while the read enable is low. A design that reloaded every edge would show the other word.
- A same-address write is watched in both modes, before and after the write edge. This catches a read path that misses the update or reports it early.

// File: rtl/flexread_pkg.sv
package flexread_pkg;

  typedef enum logic {
    RD_CLOCKED = 1'b0,
    RD_FLOW    = 1'b1
  } rd_mode_e;

  function automatic rd_mode_e mode_of(input logic sel);
    return sel ? RD_FLOW : RD_CLOCKED;
  endfunction

endpackage

// File: rtl/flexread_wport.sv
module flexread_wport #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_fire,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_word
);

  function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  assign wr_fire = wr_en;
  assign wr_idx  = slot_of(wr_addr);
  assign wr_word = wr_data;

endmodule

// File: rtl/flexread_array.sv
module flexread_array #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              wr_clk,
  input  logic              wr_fire,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] arr_rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_fire) store[wr_idx] <= wr_word;
  end

  assign arr_rdata = store[rd_idx];

endmodule

// File: rtl/flexread_rport.sv
module flexread_rport
  import flexread_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_async,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] arr_rdata,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  rd_mode_e          mode;
  logic              rd_load;
  logic [DATA_W-1:0] rd_q;

  function automatic logic [DATA_W-1:0] pick_out(input rd_mode_e m,
                                                 input logic [DATA_W-1:0] flow,
                                                 input logic [DATA_W-1:0] held);
    return (m == RD_FLOW) ? flow : held;
  endfunction

  assign mode    = mode_of(rd_async);
  assign rd_idx  = rd_addr[IDX_W-1:0];
  assign rd_load = (mode == RD_CLOCKED) && rd_en;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_load) rd_q <= arr_rdata;
  end

  assign rd_data = pick_out(mode, arr_rdata, rd_q);

  // R5
  load_word_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_load |=> (rd_q === $past(arr_rdata)));

  // R6
  hold_word_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_async && !rd_en) |=> $stable(rd_q));

  // R7
  reset_clear_chk: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_q == '0));

endmodule

// File: rtl/flexread_ram.sv
module flexread_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              rd_async,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int IDX_W = $clog2(DEPTH);

  logic              wr_fire;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_word;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] arr_rdata;

  flexread_wport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) wport_i (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_fire (wr_fire),
    .wr_idx  (wr_idx),
    .wr_word (wr_word)
  );

  flexread_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) array_i (
    .wr_clk    (wr_clk),
    .wr_fire   (wr_fire),
    .wr_idx    (wr_idx),
    .wr_word   (wr_word),
    .rd_idx    (rd_idx),
    .arr_rdata (arr_rdata)
  );

  flexread_rport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) rport_i (
    .rd_clk    (rd_clk),
    .rst_n     (rst_n),
    .rd_async  (rd_async),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .arr_rdata (arr_rdata),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );

  // R4
  same_addr_new_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (rd_async && wr_en && (wr_addr == rd_addr)) |=>
      (!rd_async || !$stable(rd_addr) || (rd_data === $past(wr_data))));

  // R2
  idle_write_chk: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (rd_async && !wr_en) |=>
      (!$stable(rd_async) || !$stable(rd_addr) || (rd_data === $past(rd_data))));

endmodule

// File: tb/flexread_ram_tb_top.sv
`timescale 1ns/100ps
module flexread_ram_tb_top;

  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [9:0]  wr_addr = '0;
  logic [17:0] wr_data = '0;
  logic        rst_n = 1'b0;
  logic        rd_async = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_addr = '0;
  logic [17:0] rd_data;

  int total = 0;
  int bad   = 0;
  logic [17:0] model [1024];

  // 250 MHz clocks, read clock offset by 1 ns so edges never coincide
  always #2 wr_clk = ~wr_clk;
  initial begin
    #1;
    forever #2 rd_clk = ~rd_clk;
  end

  flexread_ram dut_i (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_async(rd_async), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {addr, data}
  localparam logic [27:0] VEC [8] = '{
    {10'd0,    18'h3FFFF}, {10'd1023, 18'h2A5A5}, {10'd1,    18'h00001},
    {10'd512,  18'h15A5A}, {10'd511,  18'h0F0F0}, {10'd85,   18'h30303},
    {10'd170,  18'h0C0C0}, {10'd1022, 18'h20000}
  };

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [9:0] a, input logic [17:0] d, input logic en);
    @(negedge wr_clk);
    wr_addr = a; wr_data = d; wr_en = en;
    @(negedge wr_clk);
    wr_en = 1'b0;
    if (en) model[a] = d;
  endtask

  task automatic sync_read(input logic [9:0] a);
    @(negedge rd_clk);
    rd_addr = a; rd_en = 1'b1;
    @(negedge rd_clk);
    rd_en = 1'b0;
  endtask

  task automatic flow_read(input logic [9:0] a);
    rd_addr = a;
    #1;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [17:0] held;
    rd_en = 1'b1;
    repeat (4) @(negedge rd_clk);
    rst_n = 1'b1;
    rd_en = 1'b0;
    @(negedge rd_clk);
    check("R7 reset read word", rd_data, 18'h0);

    // table: write all, then read back in both modes
    for (int i = 0; i < 8; i++) do_write(VEC[i][27:18], VEC[i][17:0], 1'b1);
    for (int i = 0; i < 8; i++) begin
      sync_read(VEC[i][27:18]);
      check("R1 R5 R9 clocked readback", rd_data, model[VEC[i][27:18]]);
    end
    rd_addr = VEC[0][27:18];
    rd_async = 1'b1;
    for (int i = 0; i < 8; i++) begin
      flow_read(VEC[i][27:18]);
      check("R3 R9 flow readback", rd_data, model[VEC[i][27:18]]);
    end

    // R2: disabled write leaves word intact
    do_write(10'd85, 18'h11111, 1'b0);
    flow_read(10'd85);
    check("R2 write with enable low", rd_data, 18'h30303);

    // R4: same-address write in flow-through mode
    flow_read(10'd170);
    @(negedge wr_clk);
    wr_addr = 10'd170; wr_data = 18'h12345; wr_en = 1'b1;
    #1;
    check("R4 old word before write edge", rd_data, 18'h0C0C0);
    @(posedge wr_clk);
    #1;
    check("R4 new word after write edge", rd_data, 18'h12345);
    @(negedge wr_clk);
    wr_en = 1'b0;
    model[170] = 18'h12345;

    // R6: clocked hold with enable low
    rd_async = 1'b0;
    sync_read(10'd512);
    held = rd_data;
    check("R5 clocked load", held, 18'h15A5A);
    @(negedge rd_clk);
    rd_addr = 10'd1;
    repeat (3) @(negedge rd_clk);
    check("R6 hold with enable low", rd_data, held);

    // R8: same-address write seen by next clocked read
    sync_read(10'd511);
    check("R8 old word before write", rd_data, 18'h0F0F0);
    do_write(10'd511, 18'h3C3C3, 1'b1);
    check("R8 no change without read edge", rd_data, 18'h0F0F0);
    sync_read(10'd511);
    check("R8 new word after write", rd_data, 18'h3C3C3);

    // R9: end locations independent after neighbour writes
    do_write(10'd1022, 18'h00777, 1'b1);
    sync_read(10'd1023);
    check("R9 top address intact", rd_data, 18'h2A5A5);
    sync_read(10'd0);
    check("R9 bottom address intact", rd_data, 18'h3FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule